// File: doc/BRIEF.md
# Successive-Approximation Conversion Sequencer

This block is the digital control of a 12-bit successive-approximation converter that is read over a three-wire serial link. A falling edge on the active-low chip select freezes the sampled input (the hold output) and starts a binary search. Each internal clock the block presents a trial code to an abstracted DAC/comparator core and keeps or drops the trial bit according to the comparator answer. The conversion is timed by a counter on the free-running internal clock, so the serial clock is not needed while it runs.

The serial data output does two jobs. It is driven low while the conversion runs and goes high when the conversion ends, so a host can use its rising edge as a ready flag. Each later falling serial-clock edge presents the next result bit, most significant first. Clocks beyond the last bit shift out zeros. When chip select is high, or the shutdown input is low, the output enable is off, which stands for high impedance. A chip-select rise before the end aborts the conversion. All three control inputs are brought through two-stage synchronisers, and their edges are detected in the internal clock domain.

Top module: `sar_conv_top`

## Requirements
- R1: While reset is asserted, and right after it, `sdoOe` and `holdOn` are 0.
- R2: A synchronised falling edge of `csN` while `shdnN` is high sets `holdOn` to 1 and `sdoOe` to 1, with `sdoVal` at 0 for the whole conversion.
- R3: The conversion lasts exactly CONV_CYCLES internal clocks, with no serial clock required. Its end drops `holdOn` and drives `sdoVal` to 1 while `sdoOe` stays at 1.
- R4: The search tries 0x800 first (only the MSB set). It decides one bit per clock from MSB to LSB and keeps a bit when `cmpHigh` is 1 (input at or above the trial level). After the end of conversion, `dacCode` holds the final result.
- R5: After the end of conversion, the k-th falling `sclk` edge puts result bit 12-k on `sdoVal`. `sdoVal` changes at no other time while the output is enabled.
- R6: Falling `sclk` edges after bit 0 has been output, with `csN` still low, shift out 0.
- R7: While the synchronised `csN` is high, `sdoOe` is 0 and `holdOn` is 0.
- R8: A `csN` rise before the end of conversion aborts it: `holdOn` and `sdoOe` return to 0, and the next conversion runs normally.
- R9: While `shdnN` is low, no conversion starts and `holdOn` and `sdoOe` stay 0. Pulling `shdnN` low during a conversion aborts it.
- R10: Falling `sclk` edges during a conversion have no effect on the result.
- R11: Each control input passes through a two-stage synchroniser. A `csN` fall changes `sdoOe` on the third internal clock edge after it, and not before.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Free-running internal conversion clock |
| rstN | input | 1 | Asynchronous active-low reset |
| csN | input | 1 | Active-low chip select (asynchronous) |
| sclk | input | 1 | Serial read clock (asynchronous) |
| shdnN | input | 1 | Active-low shutdown (asynchronous) |
| cmpHigh | input | 1 | Comparator: 1 when the held input is at or above the trial level |
| dacCode | output | BITS | Trial code to the capacitive DAC |
| holdOn | output | 1 | 1 puts the sampler in hold, 0 lets it track |
| sdoVal | output | 1 | Serial data / ready flag value |
| sdoOe | output | 1 | Serial output enable; 0 means high impedance |

## Verification
A wrong search state shows up as a wrong word on the serial output. That word only appears after the whole frame has been clocked out, so the check compares the full word against the comparator's stimulus code and also reads `dacCode` right at the end of conversion. A miscounted conversion timer shows up on the first cycle in which the ready flag should rise, so that cycle is pinned exactly from both sides. A stuck read-phase state shows up within one serial clock as a missing MSB, a missing trailing zero, or an output enable that is still on after chip select rises. The shutdown and abort paths are observed through the output enable and the hold output a few internal clocks after the control input moves.

// File: rtl/sar_pkg.sv
package sar_pkg;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_CONV = 2'd1,
    ST_READ = 2'd2,
    ST_OFF  = 2'd3
  } seqState_t;

  typedef struct packed {
    logic clrSar;
    logic stepSar;
    logic latchOut;
    logic shiftBit;
  } sarStrobe_t;

endpackage

// File: rtl/sar_sync.sv
module sar_sync #(
  parameter int WIDTH = 3,
  parameter int STAGES = 2,
  parameter logic [WIDTH-1:0] RST_VAL = '0
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [WIDTH-1:0] asyncIn,
  output logic [WIDTH-1:0] syncOut
);

  logic [WIDTH-1:0] chain [STAGES];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < STAGES; i++) chain[i] <= RST_VAL;
    end else begin
      chain[0] <= asyncIn;
      for (int i = 1; i < STAGES; i++) chain[i] <= chain[i-1];
    end
  end

  assign syncOut = chain[STAGES-1];

endmodule

// File: rtl/sar_ctrl.sv
module sar_ctrl
  import sar_pkg::*;
#(
  parameter int BITS = 12,
  parameter int CONV_CYCLES = 20
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       csS,
  input  logic       sclkS,
  input  logic       shdnS,
  output sarStrobe_t strb,
  output logic       holdOn,
  output logic       sdoOe,
  output logic       sclkFall
);

  localparam int CNT_W = $clog2(CONV_CYCLES + 1);
  localparam logic [CNT_W-1:0] LAST_CNT = CNT_W'(CONV_CYCLES - 1);
  localparam logic [CNT_W-1:0] STEP_END = CNT_W'(BITS);

  seqState_t state, stateNxt;
  logic [CNT_W-1:0] convCnt, convCntNxt;
  logic csPrev, sclkPrev;
  logic csFall, csRise;

  assign csFall   = csPrev & ~csS;
  assign csRise   = ~csPrev & csS;
  assign sclkFall = sclkPrev & ~sclkS;

  always_comb begin
    stateNxt   = state;
    convCntNxt = convCnt;
    strb       = '0;
    if (!shdnS) begin
      stateNxt = ST_OFF;
    end else begin
      unique case (state)
        ST_OFF: stateNxt = ST_IDLE;
        ST_IDLE: begin
          if (csFall) begin
            stateNxt    = ST_CONV;
            convCntNxt  = '0;
            strb.clrSar = 1'b1;
          end
        end
        ST_CONV: begin
          if (csRise) begin
            stateNxt = ST_IDLE;
          end else begin
            strb.stepSar = (convCnt < STEP_END);
            convCntNxt   = convCnt + 1'b1;
            if (convCnt == LAST_CNT) begin
              stateNxt      = ST_READ;
              strb.latchOut = 1'b1;
            end
          end
        end
        ST_READ: begin
          if (csRise) stateNxt = ST_IDLE;
          else strb.shiftBit = sclkFall;
        end
        default: stateNxt = ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state    <= ST_OFF;
      convCnt  <= '0;
      csPrev   <= 1'b1;
      sclkPrev <= 1'b0;
    end else begin
      state    <= stateNxt;
      convCnt  <= convCntNxt;
      csPrev   <= csS;
      sclkPrev <= sclkS;
    end
  end

  assign holdOn = (state == ST_CONV);
  assign sdoOe  = (state == ST_CONV) || (state == ST_READ);

endmodule

// File: rtl/sar_dpath.sv
module sar_dpath
  import sar_pkg::*;
#(
  parameter int BITS = 12
) (
  input  logic            clk,
  input  logic            rstN,
  input  sarStrobe_t      strb,
  input  logic            cmpHigh,
  output logic [BITS-1:0] dacCode,
  output logic            sdoVal
);

  localparam logic [BITS-1:0] MSB_ONLY = {1'b1, {(BITS-1){1'b0}}};

  logic [BITS-1:0] resReg, bitMask, shReg;
  logic sdoReg;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      resReg  <= '0;
      bitMask <= '0;
    end else if (strb.clrSar) begin
      resReg  <= '0;
      bitMask <= MSB_ONLY;
    end else if (strb.stepSar) begin
      if (cmpHigh) resReg <= resReg | bitMask;
      bitMask <= bitMask >> 1;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      shReg  <= '0;
      sdoReg <= 1'b0;
    end else if (strb.clrSar) begin
      sdoReg <= 1'b0;
    end else if (strb.latchOut) begin
      shReg  <= resReg;
      sdoReg <= 1'b1;
    end else if (strb.shiftBit) begin
      sdoReg <= shReg[BITS-1];
      shReg  <= {shReg[BITS-2:0], 1'b0};
    end
  end

  assign dacCode = resReg | bitMask;
  assign sdoVal  = sdoReg;

endmodule

// File: rtl/sar_conv_top.sv
module sar_conv_top
  import sar_pkg::*;
#(
  parameter int BITS = 12,
  parameter int CONV_CYCLES = 20
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic            csN,
  input  logic            sclk,
  input  logic            shdnN,
  input  logic            cmpHigh,
  output logic [BITS-1:0] dacCode,
  output logic            holdOn,
  output logic            sdoVal,
  output logic            sdoOe
);

  logic [2:0] syncVec;
  logic csS, sclkS, shdnS, sclkFall;
  sarStrobe_t strb;

  sar_sync #(.WIDTH(3), .STAGES(2), .RST_VAL(3'b001)) i_sync (
    .clk(clk), .rstN(rstN),
    .asyncIn({shdnN, sclk, csN}),
    .syncOut(syncVec)
  );

  assign csS   = syncVec[0];
  assign sclkS = syncVec[1];
  assign shdnS = syncVec[2];

  sar_ctrl #(.BITS(BITS), .CONV_CYCLES(CONV_CYCLES)) i_ctrl (
    .clk(clk), .rstN(rstN),
    .csS(csS), .sclkS(sclkS), .shdnS(shdnS),
    .strb(strb), .holdOn(holdOn), .sdoOe(sdoOe), .sclkFall(sclkFall)
  );

  sar_dpath #(.BITS(BITS)) i_dpath (
    .clk(clk), .rstN(rstN),
    .strb(strb), .cmpHigh(cmpHigh),
    .dacCode(dacCode), .sdoVal(sdoVal)
  );

endmodule

// File: rtl/sar_conv_chk.sv
module sar_conv_chk #(
  parameter int BITS = 12,
  parameter int CONV_CYCLES = 20
) (
  input logic            clk,
  input logic            rstN,
  input logic            csS,
  input logic            shdnS,
  input logic            sclkFall,
  input logic            holdOn,
  input logic            sdoOe,
  input logic            sdoVal,
  input logic [BITS-1:0] dacCode
);

  localparam int RUN_W = $clog2(CONV_CYCLES + 2);
  localparam logic [RUN_W-1:0] RUN_MAX = {RUN_W{1'b1}};
  localparam logic [RUN_W-1:0] RUN_END = RUN_W'(CONV_CYCLES);
  localparam logic [BITS-1:0] FIRST_TRIAL = {1'b1, {(BITS-1){1'b0}}};

  logic [RUN_W-1:0] holdRun;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) holdRun <= '0;
    else if (!holdOn) holdRun <= '0;
    else if (holdRun != RUN_MAX) holdRun <= holdRun + 1'b1;
  end

  // R2
  hold_needs_oe_chk: assert property (@(posedge clk) disable iff (!rstN)
    holdOn |-> (sdoOe && !sdoVal));

  // R9
  shdn_blocks_chk: assert property (@(posedge clk) disable iff (!rstN)
    !shdnS |=> (!holdOn && !sdoOe));

  // R4
  first_trial_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(holdOn) |-> (dacCode == FIRST_TRIAL));

  // R3
  eoc_bound_chk: assert property (@(posedge clk) disable iff (!rstN)
    holdOn |-> (holdRun < RUN_END));

  // R3
  eoc_time_chk: assert property (@(posedge clk) disable iff (!rstN)
    ($fell(holdOn) && sdoOe) |-> (sdoVal && holdRun == RUN_END));

  // R5
  sdo_stable_chk: assert property (@(posedge clk) disable iff (!rstN)
    (sdoOe && $past(sdoOe) && !$past(holdOn) && !$past(sclkFall)) |-> $stable(sdoVal));

  // R7
  cs_high_tristate_chk: assert property (@(posedge clk) disable iff (!rstN)
    csS |=> (!sdoOe && !holdOn));

endmodule

bind sar_conv_top sar_conv_chk #(.BITS(BITS), .CONV_CYCLES(CONV_CYCLES)) i_sarChk (
  .clk(clk), .rstN(rstN), .csS(csS), .shdnS(shdnS), .sclkFall(sclkFall),
  .holdOn(holdOn), .sdoOe(sdoOe), .sdoVal(sdoVal), .dacCode(dacCode)
);

// File: tb/test_sar_conv_top.sv
module test_sar_conv_top;

  localparam int BITS = 12;
  localparam int CONV_CYCLES = 20;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic csN = 1'b1;
  logic sclk = 1'b0;
  logic shdnN = 1'b1;
  logic [BITS-1:0] stimCode = '0;
  logic cmpHigh;
  logic [BITS-1:0] dacCode;
  logic holdOn, sdoVal, sdoOe;

  int total = 0;
  int bad = 0;
  bit finished = 1'b0;

  assign cmpHigh = (stimCode >= dacCode);

  always #2 clk = ~clk;

  sar_conv_top #(.BITS(BITS), .CONV_CYCLES(CONV_CYCLES)) i_sar_conv_top (
    .clk(clk), .rstN(rstN), .csN(csN), .sclk(sclk), .shdnN(shdnN),
    .cmpHigh(cmpHigh), .dacCode(dacCode), .holdOn(holdOn),
    .sdoVal(sdoVal), .sdoOe(sdoOe)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic waitClk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic resetTest();
    rstN = 1'b0;
    waitClk(3);
    chk(!sdoOe && !holdOn, "R1", "oe/hold in reset", {sdoOe, holdOn}, 0);
    rstN = 1'b1;
    waitClk(1);
    chk(!sdoOe && !holdOn, "R1", "oe/hold after reset", {sdoOe, holdOn}, 0);
    waitClk(5);
  endtask

  task automatic convTest(input logic [BITS-1:0] code, input bit noisy);
    logic [BITS-1:0] got;
    logic prevBit;
    stimCode = code;
    waitClk(1);
    csN = 1'b0;
    waitClk(2);
    chk(!sdoOe, "R11", "oe before sync latency", sdoOe, 0);
    waitClk(1);
    chk(sdoOe && holdOn && !sdoVal, "R2", "conversion start", {sdoOe, holdOn, sdoVal}, 3'b110);
    if (noisy) begin
      // R10: serial clock toggled while converting
      repeat (3) begin
        sclk = 1'b1; waitClk(2);
        sclk = 1'b0; waitClk(2);
      end
    end else begin
      waitClk(12);
    end
    chk(holdOn && !sdoVal, "R3", "still converting at 15", {holdOn, sdoVal}, 2'b10);
    waitClk(7);
    chk(holdOn && !sdoVal, "R3", "still converting at 22", {holdOn, sdoVal}, 2'b10);
    waitClk(1);
    chk(!holdOn && sdoOe && sdoVal, "R3", "end flag at 23", {holdOn, sdoOe, sdoVal}, 3'b011);
    chk(dacCode == code, noisy ? "R10" : "R4", "final dac code", dacCode, code);
    got = '0;
    prevBit = 1'b1;
    for (int i = 0; i < BITS; i++) begin
      sclk = 1'b1;
      waitClk(4);
      chk(sdoVal == prevBit, "R5", "stable before fall", sdoVal, prevBit);
      sclk = 1'b0;
      waitClk(4);
      got[BITS-1-i] = sdoVal;
      prevBit = sdoVal;
    end
    chk(got == code, noisy ? "R10" : "R5", "serial word", got, code);
    for (int j = 0; j < 3; j++) begin
      sclk = 1'b1; waitClk(4);
      sclk = 1'b0; waitClk(4);
      chk(sdoOe && !sdoVal, "R6", "trailing zero", {sdoOe, sdoVal}, 2'b10);
    end
    csN = 1'b1;
    waitClk(3);
    chk(!sdoOe && !holdOn, "R7", "released after cs high", {sdoOe, holdOn}, 0);
    waitClk(4);
  endtask

  task automatic abortTest();
    stimCode = 12'h3C3;
    waitClk(1);
    csN = 1'b0;
    waitClk(10);
    chk(holdOn, "R8", "converting before abort", holdOn, 1);
    csN = 1'b1;
    waitClk(3);
    chk(!sdoOe && !holdOn, "R8", "aborted", {sdoOe, holdOn}, 0);
    waitClk(30);
    chk(!sdoOe && !holdOn, "R8", "stays idle after abort", {sdoOe, holdOn}, 0);
    convTest(12'h5A1, 1'b0);
  endtask

  task automatic shdnTest();
    shdnN = 1'b0;
    waitClk(4);
    csN = 1'b0;
    waitClk(30);
    chk(!sdoOe && !holdOn, "R9", "no start in shutdown", {sdoOe, holdOn}, 0);
    csN = 1'b1;
    shdnN = 1'b1;
    waitClk(6);
    stimCode = 12'h123;
    csN = 1'b0;
    waitClk(8);
    chk(holdOn, "R9", "converting before shutdown", holdOn, 1);
    shdnN = 1'b0;
    waitClk(3);
    chk(!sdoOe && !holdOn, "R9", "shutdown aborts", {sdoOe, holdOn}, 0);
    csN = 1'b1;
    shdnN = 1'b1;
    waitClk(6);
    convTest(12'hC35, 1'b0);
  endtask

  initial begin
    #(200000 * 4);
    if (!finished) begin
      total++;
      bad++;
      $display("FAIL watchdog expired actual=1 expected=0");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    resetTest();
    convTest(12'h000, 1'b0);
    convTest(12'hFFF, 1'b0);
    convTest(12'h800, 1'b0);
    convTest(12'h7FF, 1'b0);
    convTest(12'hA5C, 1'b0);
    convTest(12'h001, 1'b0);
    convTest(12'h6B9, 1'b1);
    abortTest();
    shdnTest();
    finished = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule